// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This block carries out the three vector configuration instructions of a vector unit whose register width is 128 bits. The instruction forms differ in where they take the requested element count (AVL) and the new type word from. One form takes a register AVL and an immediate type. One takes a 5-bit immediate AVL and an immediate type. One takes both from registers. On an accepted request the block updates its vector-length register `vl` and its type register `vtype`. It also reports the largest element count allowed by the stored type, and the register width in bytes.

The maximum count is found by shifts alone. The element-width code and the signed 3-bit group-multiplier code are summed into a base-2 logarithm. One shifted by that logarithm is the limit. Fractional groupings therefore need no divider and no fractional arithmetic. An illegal type leaves only the illegal flag set in `vtype` and forces `vl` to zero. The decoder upstream supplies the register indices and operand values. This block holds only the two configuration registers.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, `vl_o` is 0, `vtype_o` holds only the illegal flag in bit 31, and `vlmax_o` is 0.
- R2: When `cfg_valid` is low, `vl_o` and `vtype_o` keep their values.
- R3: A type word is illegal if any of the following holds: a bit in [31:8] is set, the width code in [5:3] exceeds 2, or the multiplier code in [2:0] is 100. Width codes 0, 1 and 2 mean 8, 16 and 32 bits.
- R4: After an illegal request, `vtype_o` equals 0x8000_0000 and `vl_o` is 0.
- R5: Multiplier codes 000–011 mean 1, 2, 4 and 8, and codes 101, 110 and 111 mean 1/8, 1/4 and 1/2. The maximum count is multiplier × 128 / element width. A pair that gives a maximum below 1 is illegal.
- R6: `cfg_op` 00 takes the AVL from `avl_reg` and the type from `vtype_imm`. Code 01 takes the AVL from `avl_imm` and the type from `vtype_imm`. Code 10 takes both from `avl_reg` and `vtype_reg`. Code 11 changes nothing. The immediates are zero-extended.
- R7: For a legal request, `vl_o` becomes the AVL when the AVL is at most the maximum. Otherwise it becomes the maximum.
- R8: For register-AVL forms with `rs1_idx` = 0 and `rd_idx` ≠ 0, `vl_o` becomes the maximum.
- R9: For register-AVL forms with `rs1_idx` = 0 and `rd_idx` = 0, a legal request updates `vtype_o` and leaves `vl_o` unchanged.
- R10: The policy bits 6 and 7 are stored in `vtype_o` and have no effect on `vl_o` or `vlmax_o`.
- R11: `vlenb_o` always reads 16.
- R12: `vlmax_o` gives the maximum count for the stored type, and reads 0 while the illegal flag is set.
- R13: `vl_o` and `vtype_o` take their new values at the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Request strobe for one configuration instruction |
| cfg_op | input | 2 | Instruction form selector |
| rs1_idx | input | 5 | Index of the AVL source register |
| rd_idx | input | 5 | Index of the destination register |
| avl_reg | input | 32 | AVL value read from the scalar register |
| avl_imm | input | 5 | Immediate AVL |
| vtype_imm | input | 11 | Immediate type word |
| vtype_reg | input | 32 | Type word read from the scalar register |
| vl_o | output | 32 | Current vector length |
| vtype_o | output | 32 | Current type register |
| vlmax_o | output | 32 | Maximum count for the stored type |
| vlenb_o | output | 32 | Register width in bytes |

## Verification
The assertions assume two things about the inputs. `cfg_op`, the register indices and the operand values are steady around each clock edge. A request's legality is judged from the operands present in the cycle where `cfg_valid` is sampled. The bench changes inputs only at falling edges. It mixes directed requests with random ones whose type words mostly fall in the low eight bits, so that legal and illegal settings both occur often. It also keeps some requests on the keep-length path, where the stored length may exceed a smaller new maximum. The clamp assertion therefore leaves that path out.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam int LMUL_LO   = 0;
  localparam int SEW_LO    = 3;
  localparam int FIELD_W   = 3;
  localparam int POLICY_HI = 7;
  localparam int ZIMM_W    = 11;
  localparam int UIMM_W    = 5;

  typedef enum logic [1:0] {
    CFG_REG_AVL = 2'b00,
    CFG_IMM_AVL = 2'b01,
    CFG_REG_ALL = 2'b10,
    CFG_NOP     = 2'b11
  } cfg_op_e;

  // Base-2 log of the element limit. The multiplier code is read as a
  // signed 3-bit value, so the fractional settings become negative terms.
  function automatic int limit_log2(input int log2_vlen,
                                    input logic [FIELD_W-1:0] sew_code,
                                    input logic [FIELD_W-1:0] lmul_code);
    int sew_term;
    int lmul_term;
    sew_term  = int'(sew_code) + 3;
    lmul_term = int'($signed(lmul_code));
    return log2_vlen - sew_term + lmul_term;
  endfunction

endpackage

// File: rtl/vcfg_src_sel.sv
module vcfg_src_sel
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]        cfg_op,
  input  logic [4:0]        rs1_idx,
  input  logic [4:0]        rd_idx,
  input  logic [XLEN-1:0]   avl_reg,
  input  logic [UIMM_W-1:0] avl_imm,
  input  logic [ZIMM_W-1:0] vtype_imm,
  input  logic [XLEN-1:0]   vtype_reg,
  output logic [XLEN-1:0]   avl_sel,
  output logic [XLEN-1:0]   vtype_sel,
  output logic              take_max,
  output logic              keep_len,
  output logic              op_active
);

  logic reg_avl_form;
  logic rs1_zero;

  always_comb begin
    reg_avl_form = (cfg_op == CFG_REG_AVL) || (cfg_op == CFG_REG_ALL);
    rs1_zero     = (rs1_idx == 5'd0);
    op_active    = (cfg_op != CFG_NOP);

    avl_sel = (cfg_op == CFG_IMM_AVL) ? XLEN'(avl_imm) : avl_reg;
    vtype_sel = (cfg_op == CFG_REG_ALL) ? vtype_reg : XLEN'(vtype_imm);

    take_max = reg_avl_form && rs1_zero && (rd_idx != 5'd0);
    keep_len = reg_avl_form && rs1_zero && (rd_idx == 5'd0);
  end

endmodule

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 32
) (
  input  logic [XLEN-1:0] vtype_in,
  output logic            legal,
  output logic [XLEN-1:0] limit,
  output logic [XLEN-1:0] vtype_clean
);

  localparam int LOG2_VLEN    = $clog2(VLEN);
  localparam int MAX_SEW_CODE = $clog2(ELEN / 8);
  localparam int KEEP_W       = POLICY_HI + 1;

  logic [FIELD_W-1:0] sew_code;
  logic [FIELD_W-1:0] lmul_code;
  logic               upper_clear;
  logic               sew_ok;
  logic               lmul_ok;
  logic               size_ok;
  int                 lg;

  always_comb begin
    sew_code    = vtype_in[SEW_LO +: FIELD_W];
    lmul_code   = vtype_in[LMUL_LO +: FIELD_W];
    upper_clear = (vtype_in[XLEN-1:KEEP_W] == '0);
    sew_ok      = int'(sew_code) <= MAX_SEW_CODE;
    lmul_ok     = (lmul_code != 3'b100);
    lg          = limit_log2(LOG2_VLEN, sew_code, lmul_code);
    size_ok     = (lg >= 0);
    legal       = upper_clear && sew_ok && lmul_ok && size_ok;
    limit       = legal ? (XLEN'(1) << lg[4:0]) : '0;
    vtype_clean = {{(XLEN-KEEP_W){1'b0}}, vtype_in[KEEP_W-1:0]};
  end

endmodule

// File: rtl/vcfg_len_clamp.sv
module vcfg_len_clamp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] avl,
  input  logic [XLEN-1:0] limit,
  input  logic            take_max,
  input  logic            legal,
  output logic [XLEN-1:0] len_next
);

  always_comb begin
    if (!legal)
      len_next = '0;
    else if (take_max || (avl > limit))
      len_next = limit;
    else
      len_next = avl;
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [4:0]        rs1_idx,
  input  logic [4:0]        rd_idx,
  input  logic [XLEN-1:0]   avl_reg,
  input  logic [4:0]        avl_imm,
  input  logic [10:0]       vtype_imm,
  input  logic [XLEN-1:0]   vtype_reg,
  output logic [XLEN-1:0]   vl_o,
  output logic [XLEN-1:0]   vtype_o,
  output logic [XLEN-1:0]   vlmax_o,
  output logic [XLEN-1:0]   vlenb_o
);

  localparam int          LOG2_VLEN = $clog2(VLEN);
  localparam logic [XLEN-1:0] VILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] avl_sel;
  logic [XLEN-1:0] vtype_sel;
  logic            take_max;
  logic            keep_len;
  logic            op_active;
  logic            cfg_legal;
  logic            cfg_illegal;
  logic [XLEN-1:0] new_limit;
  logic [XLEN-1:0] vtype_clean;
  logic [XLEN-1:0] len_next;
  logic            cfg_fire;
  logic [XLEN-1:0] vl_q;
  logic [XLEN-1:0] vtype_q;
  int              cur_lg;

  vcfg_src_sel #(.XLEN(XLEN)) u_src (
    .cfg_op    (cfg_op),
    .rs1_idx   (rs1_idx),
    .rd_idx    (rd_idx),
    .avl_reg   (avl_reg),
    .avl_imm   (avl_imm),
    .vtype_imm (vtype_imm),
    .vtype_reg (vtype_reg),
    .avl_sel   (avl_sel),
    .vtype_sel (vtype_sel),
    .take_max  (take_max),
    .keep_len  (keep_len),
    .op_active (op_active)
  );

  vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_chk_type (
    .vtype_in    (vtype_sel),
    .legal       (cfg_legal),
    .limit       (new_limit),
    .vtype_clean (vtype_clean)
  );

  vcfg_len_clamp #(.XLEN(XLEN)) u_clamp (
    .avl      (avl_sel),
    .limit    (new_limit),
    .take_max (take_max),
    .legal    (cfg_legal),
    .len_next (len_next)
  );

  assign cfg_illegal = !cfg_legal;
  assign cfg_fire    = cfg_valid && op_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      vtype_q <= VILL_ONLY;
    end else if (cfg_fire) begin
      if (cfg_illegal) begin
        vl_q    <= '0;
        vtype_q <= VILL_ONLY;
      end else begin
        vtype_q <= vtype_clean;
        if (!keep_len)
          vl_q <= len_next;
      end
    end
  end

  always_comb begin
    cur_lg  = limit_log2(LOG2_VLEN, vtype_q[SEW_LO +: FIELD_W], vtype_q[LMUL_LO +: FIELD_W]);
    vlmax_o = vtype_q[XLEN-1] ? '0 : (XLEN'(1) << cur_lg[4:0]);
  end

  assign vl_o    = vl_q;
  assign vtype_o = vtype_q;
  assign vlenb_o = XLEN'(VLEN / 8);

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_valid,
  input logic [1:0]      cfg_op,
  input logic [4:0]      rs1_idx,
  input logic [4:0]      rd_idx,
  input logic [XLEN-1:0] vl_o,
  input logic [XLEN-1:0] vtype_o,
  input logic [XLEN-1:0] vlmax_o,
  input logic            cfg_illegal,
  input logic            keep_len
);

  localparam logic [XLEN-1:0] VILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  logic reg_form;
  assign reg_form = (cfg_op == 2'b00) || (cfg_op == 2'b10);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vtype_o == VILL_ONLY) && (vl_o == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> $stable(vl_o) && $stable(vtype_o));

  assert_illegal_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_op != 2'b11 && cfg_illegal) |=> (vtype_o == VILL_ONLY) && (vl_o == '0));

  assert_vill_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_o[XLEN-1] |-> (vl_o == '0) && (vtype_o[XLEN-2:0] == '0));

  assert_nop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_op == 2'b11) |=> $stable(vl_o) && $stable(vtype_o));

  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_op != 2'b11 && !keep_len) |=> (vl_o <= vlmax_o));

  assert_take_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && reg_form && rs1_idx == 5'd0 && rd_idx != 5'd0 && !cfg_illegal)
      |=> (vl_o == vlmax_o));

  assert_keep_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && reg_form && rs1_idx == 5'd0 && rd_idx == 5'd0 && !cfg_illegal)
      |=> $stable(vl_o));

  assert_limit_pow2_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vlmax_o) <= 1);

  assert_vill_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_o[XLEN-1] |-> (vlmax_o == '0));

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN)) u_vcfg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_valid   (cfg_valid),
  .cfg_op      (cfg_op),
  .rs1_idx     (rs1_idx),
  .rd_idx      (rd_idx),
  .vl_o        (vl_o),
  .vtype_o     (vtype_o),
  .vlmax_o     (vlmax_o),
  .cfg_illegal (cfg_illegal),
  .keep_len    (keep_len)
);

// File: tb/vcfg_unit_tb.sv
`timescale 1ns/1ps
module vcfg_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_op = 2'b11;
  logic [4:0]  rs1_idx = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] avl_reg = '0;
  logic [4:0]  avl_imm = '0;
  logic [10:0] vtype_imm = '0;
  logic [31:0] vtype_reg = '0;
  logic [31:0] vl_o, vtype_o, vlmax_o, vlenb_o;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  longint m_vl = 0;
  logic [31:0] m_vtype = 32'h8000_0000;

  always #2.5 clk = ~clk;

  vcfg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .rs1_idx(rs1_idx), .rd_idx(rd_idx), .avl_reg(avl_reg), .avl_imm(avl_imm),
    .vtype_imm(vtype_imm), .vtype_reg(vtype_reg),
    .vl_o(vl_o), .vtype_o(vtype_o), .vlmax_o(vlmax_o), .vlenb_o(vlenb_o)
  );

  function automatic longint ref_limit(logic [31:0] vt);
    longint per_reg;
    int s, m;
    if (vt[31]) return 0;
    s = int'(vt[5:3]);
    m = int'(vt[2:0]);
    if (s > 2) return 0;
    per_reg = 128 / (8 * (1 << s));
    if (m < 4) return per_reg * (1 << m);
    if (m == 4) return 0;
    return per_reg / (1 << (8 - m));
  endfunction

  function automatic bit ref_legal(logic [31:0] vt);
    if (vt[31:8] != 0) return 0;
    if (vt[5:3] > 3'd2) return 0;
    if (vt[2:0] == 3'b100) return 0;
    return ref_limit(vt) >= 1;
  endfunction

  task automatic check(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("vl", vl_o, m_vl);
    check("vtype", vtype_o, m_vtype);
    check("vlmax", vlmax_o, ref_limit(m_vtype));
    check("vlenb R11", vlenb_o, 16);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one request: drive after falling edge, model at rising edge, compare at next falling edge
  task automatic step(bit v, logic [1:0] op, logic [4:0] r1, logic [4:0] rd,
                      logic [31:0] areg, logic [4:0] aimm,
                      logic [10:0] vimm, logic [31:0] vreg);
    logic [31:0] vt;
    longint avl, lim;
    cfg_valid = v; cfg_op = op; rs1_idx = r1; rd_idx = rd;
    avl_reg = areg; avl_imm = aimm; vtype_imm = vimm; vtype_reg = vreg;
    @(posedge clk);
    if (v && op != 2'b11) begin
      vt  = (op == 2'b10) ? vreg : {21'd0, vimm};
      avl = (op == 2'b01) ? longint'(aimm) : longint'(areg);
      if (!ref_legal(vt)) begin
        m_vtype = 32'h8000_0000;
        m_vl = 0;
      end else begin
        lim = ref_limit(vt);
        m_vtype = vt;
        if (op != 2'b01 && r1 == 0 && rd == 0) m_vl = m_vl;
        else if (op != 2'b01 && r1 == 0) m_vl = lim;
        else m_vl = (avl <= lim) ? avl : lim;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();               // R1 reset state, held in reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: inputs toggle but no strobe
    tag = "R2";
    step(0, 2'b00, 5'd3, 5'd4, 32'd7, 5'd2, 11'h008, 32'h10);
    step(0, 2'b10, 5'd3, 5'd4, 32'd9, 5'd2, 11'h000, 32'h008);

    // R6: each form and source
    tag = "R6";
    step(1, 2'b00, 5'd1, 5'd2, 32'd5, 5'd30, 11'h008, 32'h0);    // sew16 m1 -> 8, vl 5
    step(1, 2'b01, 5'd1, 5'd2, 32'd99, 5'd3, 11'h000, 32'h0);    // sew8 m1, avl 3
    step(1, 2'b10, 5'd1, 5'd2, 32'd11, 5'd0, 11'h7ff, 32'h011);  // sew32 m2 -> 8
    step(1, 2'b11, 5'd1, 5'd2, 32'd1, 5'd1, 11'h000, 32'h0);     // no change

    // R7: clamp boundaries, sew8 m1 limit 16
    tag = "R7";
    step(1, 2'b00, 5'd5, 5'd6, 32'd16, 5'd0, 11'h000, 32'h0);
    step(1, 2'b00, 5'd5, 5'd6, 32'd17, 5'd0, 11'h000, 32'h0);
    step(1, 2'b00, 5'd5, 5'd6, 32'hffff_ffff, 5'd0, 11'h003, 32'h0); // m8 -> 128
    step(1, 2'b00, 5'd5, 5'd6, 32'd0, 5'd0, 11'h003, 32'h0);

    // R5 / R12: full sweep of width and multiplier codes
    tag = "R5";
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        step(1, 2'b10, 5'd7, 5'd8, 32'd1000, 5'd0, 11'd0, 32'((s << 3) | m));

    // R3 / R4: reserved bits, bad codes
    tag = "R3";
    step(1, 2'b00, 5'd7, 5'd8, 32'd4, 5'd0, 11'h100, 32'h0);
    step(1, 2'b00, 5'd7, 5'd8, 32'd4, 5'd0, 11'h004, 32'h0);
    step(1, 2'b00, 5'd7, 5'd8, 32'd4, 5'd0, 11'h018, 32'h0);
    tag = "R4";
    step(1, 2'b00, 5'd7, 5'd8, 32'd4, 5'd0, 11'h000, 32'h0);
    step(1, 2'b10, 5'd7, 5'd8, 32'd4, 5'd0, 11'h000, 32'h8000_0000);
    step(1, 2'b10, 5'd7, 5'd8, 32'd4, 5'd0, 11'h000, 32'h0000_0015); // sew32 1/8

    // R8: rs1 = x0, rd != x0
    tag = "R8";
    step(1, 2'b00, 5'd0, 5'd9, 32'd2, 5'd0, 11'h00e, 32'h0);   // sew16 1/4 -> 2
    step(1, 2'b10, 5'd0, 5'd9, 32'd2, 5'd0, 11'h000, 32'h002); // m4 -> 64

    // R9: rs1 = rd = x0 keeps vl
    tag = "R9";
    step(1, 2'b00, 5'd0, 5'd0, 32'd1, 5'd0, 11'h009, 32'h0);
    step(1, 2'b00, 5'd0, 5'd0, 32'd1, 5'd0, 11'h010, 32'h0);

    // R10: policy bits change nothing but themselves
    tag = "R10";
    step(1, 2'b00, 5'd3, 5'd3, 32'd6, 5'd0, 11'h0c9, 32'h0);
    step(1, 2'b00, 5'd3, 5'd3, 32'd6, 5'd0, 11'h049, 32'h0);

    // R13 plus wide coverage by random requests
    tag = "R13";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] vr;
      vr = (($urandom % 8) == 0) ? $urandom : ($urandom & 32'hff);
      step(($urandom % 4) != 0, 2'($urandom), 5'($urandom % 3), 5'($urandom % 3),
           ($urandom % 2) ? ($urandom % 160) : $urandom, 5'($urandom),
           11'($urandom & (($urandom % 6) == 0 ? 32'h7ff : 32'hff)), vr);
    end

    finish_run();
  end

endmodule